// File: doc/BRIEF.md
# Bus Master Cycle Controller

This block turns one host read or write at a time into a parallel-bus master cycle. It supports 16-, 24- and 32-bit address spaces, and byte, 16-bit and 32-bit data widths. Byte transfers go to either the even or the odd byte lane. The host holds a request level with address, space, size, direction and write data. The block wins the bus, or reuses a bus it already owns. It then drives the address strobe, followed by the data strobes for the lanes in use. It waits for the slave's acknowledge or bus-error input, and finally returns a one-cycle acknowledge pulse to the host.

An 8-bit control register at offset 0x10 selects the special cycle types:
- a read-modify-write pair that keeps the address strobe low between its read and its write;
- an address-only cycle that moves no data;
- a choice of bus-ownership policy: keep the bus until another requester asks for it, or release it after every cycle.

The same register holds a sticky bus-error flag, cleared by writing one to it, and an enable that routes that flag to an interrupt line. A posted-write bit can be stored and read back, but writes are always completed with a full handshake.

Top module: `vbus_master_ctl`

## Requirements
- R1: After reset the control register reads 0x00, the address strobe, both data strobes and the busy line are inactive, the bus request is low, and the host acknowledge and interrupt are low.
- R2: The control register answers at offset 0x10 with bit0 = read-modify-write, bit1 = release-after-each-cycle, bit2 = bus-error flag, bit3 = bus-error interrupt enable, bit4 = posted-write, bit5 = address-only. Bits 7..6 read 0, and any other offset reads 0x00.
- R3: When the bus is not owned, a host access raises the bus request until grant. It then drives the address strobe low, then the data strobes. It completes with a one-cycle host acknowledge only after the slave acknowledge, returning the read data without error. The address on the bus is masked to 16 bits for space code 0 and to 24 bits for space code 1; codes 2 and 3 pass all 32 bits.
- R4: Size code 0 is a byte, code 1 is 16 bits, and codes 2 and 3 are 32 bits. An even byte (address bit 0 = 0) uses bus bits 15..8 and drives ds_n = 2'b01. An odd byte uses bits 7..0 and drives ds_n = 2'b10. The 16-bit size uses bits 15..0 and the 32-bit size uses bits 31..0, both with ds_n = 2'b00. Read bytes are returned right-justified.
- R5: With bit0 set, a read is followed by the host's next write as a pair. The address strobe stays low from the read's address phase until the write completes, and the bit clears itself afterwards.
- R6: With bit5 set, a byte or 16-bit read makes an address-only cycle. The address strobe is asserted, no data strobe is asserted, and the cycle is acknowledged without error. Bit5 clears itself afterwards.
- R7: With bit5 set, a write or a 32-bit read is rejected. The acknowledge comes with the error flag, no bus strobe is asserted, and bit5 stays set.
- R8: An asserted bus-error input during a data phase sets bit2 and ends the access with the error flag and read data 0xFFFFFFFF. Writing 1 to bit2 clears it, and writing 0 to bit2 leaves it unchanged.
- R9: The interrupt output is high exactly while both bit2 and bit3 are set.
- R10: With bit1 = 0 the busy line stays high after a cycle, and the next access starts without a bus request. While the block is idle with no host request, an active other-requester input drops the busy line.
- R11: With bit1 = 1 the busy line drops after every cycle, and each access raises the bus request again.
- R12: Setting bit4 changes nothing. A write still ends only after the slave acknowledge has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hreq | input | 1 | Host request level, held until hack |
| hwrite | input | 1 | Host access is a write |
| haddr | input | 32 | Host address |
| hspace | input | 2 | Address space: 0 = 16-bit, 1 = 24-bit, 2/3 = 32-bit |
| hsize | input | 2 | Data size: 0 = byte, 1 = 16-bit, 2/3 = 32-bit |
| hwdata | input | 32 | Host write data, right-justified |
| hack | output | 1 | One-cycle host acknowledge |
| herr | output | 1 | Error flag, valid with hack |
| hrdata | output | 32 | Read data, valid with hack |
| rsel | input | 1 | Register port select |
| rwr | input | 1 | Register write strobe |
| roff | input | 8 | Register offset |
| rwdata | input | 8 | Register write data |
| rrdata | output | 8 | Register read data (combinational) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_other_req | input | 1 | Another requester wants the bus |
| bbsy | output | 1 | Bus busy, high while the block owns the bus |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 2 | Data strobes, active low; bit1 = lane 15..8, bit0 = lane 7..0 |
| write_n | output | 1 | Low for a write data phase |
| bus_space | output | 2 | Address space code of the cycle |
| bus_addr | output | 32 | Masked bus address |
| bus_dout | output | 32 | Write data on its byte lanes |
| bus_din | input | 32 | Read data from the slave |
| dtack_n | input | 1 | Slave acknowledge, active low |
| berr_n | input | 1 | Bus error, active low |
| irq | output | 1 | Bus-error interrupt |

## Verification
The bench targets the lane steering for even and odd bytes. A design that swapped them would return the wrong byte and strobe the wrong lane. For the read-modify-write pair the bench counts address-strobe releases: a design that dropped the strobe between read and write would show two releases, and one that failed to self-clear would leave bit0 set. For address-only mode it checks both the legal reads and the rejected write and 32-bit read. A wrong design would put a data strobe on the bus, or clear the mode bit on a rejected request. It also exercises the write-one-to-clear flag, which would clear on a zero write if done wrong, and both ownership policies, where a swapped policy shows up as a missing or extra bus request.

// File: rtl/vbm_pkg.sv
package vbm_pkg;

  localparam int BUS_AW = 32;
  localparam int BUS_DW = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SP_A16  = 2'd0;
  localparam logic [1:0] SP_A24  = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_ADDR, ST_DATA, ST_RACK, ST_HOLD, ST_END, ST_REJ
  } seq_st_e;

  // Field order is the register bit order, bit5 down to bit0.
  typedef struct packed {
    logic aonly;
    logic postwr;
    logic ien;
    logic berr;
    logic rwd;
    logic rmw;
  } ctrl_t;

  // Active-high lane enables: bit1 = bits 15..8, bit0 = bits 7..0.
  function automatic logic [1:0] lane_strobe(input logic [1:0] sz, input logic a0);
    if (sz == SZ_BYTE) return a0 ? 2'b01 : 2'b10;
    return 2'b11;
  endfunction

  function automatic logic [BUS_DW-1:0] lane_pack(input logic [1:0] sz, input logic a0,
                                                  input logic [BUS_DW-1:0] wd);
    logic [BUS_DW-1:0] r;
    r = '0;
    case (sz)
      SZ_BYTE: if (a0) r[7:0] = wd[7:0]; else r[15:8] = wd[7:0];
      SZ_WORD: r[15:0] = wd[15:0];
      default: r = wd;
    endcase
    return r;
  endfunction

  function automatic logic [BUS_DW-1:0] lane_unpack(input logic [1:0] sz, input logic a0,
                                                    input logic [BUS_DW-1:0] rd);
    logic [BUS_DW-1:0] r;
    r = '0;
    case (sz)
      SZ_BYTE: r[7:0] = a0 ? rd[7:0] : rd[15:8];
      SZ_WORD: r[15:0] = rd[15:0];
      default: r = rd;
    endcase
    return r;
  endfunction

  function automatic logic [BUS_AW-1:0] space_mask(input logic [1:0] sp,
                                                   input logic [BUS_AW-1:0] a);
    logic [BUS_AW-1:0] r;
    r = a;
    if (sp == SP_A16) r[BUS_AW-1:16] = '0;
    else if (sp == SP_A24) r[BUS_AW-1:24] = '0;
    return r;
  endfunction

  function automatic logic aonly_legal(input logic wr, input logic [1:0] sz);
    return !wr && (sz == SZ_BYTE || sz == SZ_WORD);
  endfunction

endpackage

// File: rtl/vbm_ctrl_reg.sv
module vbm_ctrl_reg
  import vbm_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] CTRL_OFF = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsel,
  input  logic             rwr,
  input  logic [OFF_W-1:0] roff,
  input  logic [7:0]       rwdata,
  output logic [7:0]       rrdata,
  input  logic             clr_rmw,
  input  logic             clr_aonly,
  input  logic             set_berr,
  output ctrl_t            ctrl
);

  localparam int CW = $bits(ctrl_t);

  logic hit, wr_hit;
  logic [1:0] unused_hi;

  assign hit       = rsel && (roff == CTRL_OFF);
  assign wr_hit    = hit && rwr;
  assign unused_hi = rwdata[7:6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_hit) begin
        ctrl.rmw    <= rwdata[0];
        ctrl.rwd    <= rwdata[1];
        ctrl.ien    <= rwdata[3];
        ctrl.postwr <= rwdata[4];
        ctrl.aonly  <= rwdata[5];
      end
      if (clr_rmw)   ctrl.rmw   <= 1'b0;
      if (clr_aonly) ctrl.aonly <= 1'b0;
      if (set_berr)                   ctrl.berr <= 1'b1;
      else if (wr_hit && rwdata[2])   ctrl.berr <= 1'b0;
    end
  end

  assign rrdata = hit ? {{(8-CW){1'b0}}, ctrl} : 8'h00;

endmodule

// File: rtl/vbm_owner.sv
module vbm_owner (
  input  logic clk,
  input  logic rst_n,
  input  logic take_bus,
  input  logic cyc_done,
  input  logic rwd,
  input  logic rel_ok,
  input  logic other_req,
  output logic own
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      own <= 1'b0;
    else if (take_bus)               own <= 1'b1;
    else if (cyc_done && rwd)        own <= 1'b0;
    else if (rel_ok && other_req)    own <= 1'b0;
  end

endmodule

// File: rtl/vbm_seq.sv
module vbm_seq
  import vbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hreq,
  input  logic              hwrite,
  input  logic [BUS_AW-1:0] haddr,
  input  logic [1:0]        hspace,
  input  logic [1:0]        hsize,
  input  logic [BUS_DW-1:0] hwdata,
  output logic              hack,
  output logic              herr,
  output logic [BUS_DW-1:0] hrdata,
  input  logic              mode_rmw,
  input  logic              mode_aonly,
  input  logic              own,
  output logic              take_bus,
  output logic              cyc_done,
  output logic              rel_ok,
  output logic              clr_rmw,
  output logic              clr_aonly,
  output logic              set_berr,
  output logic              aonly_cyc,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              as_n,
  output logic [1:0]        ds_n,
  output logic              write_n,
  output logic [1:0]        bus_space,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [BUS_DW-1:0] bus_dout,
  input  logic [BUS_DW-1:0] bus_din,
  input  logic              dtack_n,
  input  logic              berr_n
);

  seq_st_e           st;
  logic              c_wr, c_a0, c_aonly, c_rmw, err_q;
  logic [1:0]        c_sz;
  logic [BUS_DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      c_wr      <= 1'b0;
      c_a0      <= 1'b0;
      c_aonly   <= 1'b0;
      c_rmw     <= 1'b0;
      err_q     <= 1'b0;
      c_sz      <= SZ_BYTE;
      rdata_q   <= '0;
      bus_space <= '0;
      bus_addr  <= '0;
      bus_dout  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (hreq) begin
          c_wr      <= hwrite;
          c_a0      <= haddr[0];
          c_sz      <= hsize;
          c_aonly   <= mode_aonly;
          c_rmw     <= mode_rmw && !hwrite && !mode_aonly;
          bus_space <= hspace;
          bus_addr  <= space_mask(hspace, haddr);
          bus_dout  <= lane_pack(hsize, haddr[0], hwdata);
          rdata_q   <= '0;
          err_q     <= 1'b0;
          if (mode_aonly && !aonly_legal(hwrite, hsize)) begin
            err_q <= 1'b1;
            st    <= ST_REJ;
          end else begin
            st <= own ? ST_ADDR : ST_ARB;
          end
        end
        ST_ARB:  if (bus_grant) st <= ST_ADDR;
        ST_ADDR: st <= c_aonly ? ST_END : ST_DATA;
        ST_DATA: begin
          if (!berr_n) begin
            err_q   <= 1'b1;
            rdata_q <= '1;
            st      <= ST_END;
          end else if (!dtack_n) begin
            if (!c_wr) rdata_q <= lane_unpack(c_sz, c_a0, bus_din);
            st <= (c_rmw && !c_wr) ? ST_RACK : ST_END;
          end
        end
        ST_RACK: st <= ST_HOLD;
        ST_HOLD: if (hreq && hwrite) begin
          c_wr     <= 1'b1;
          bus_dout <= lane_pack(c_sz, c_a0, hwdata);
          st       <= ST_DATA;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    as_n      = !(st == ST_ADDR || st == ST_DATA || st == ST_RACK || st == ST_HOLD);
    ds_n      = (st == ST_DATA) ? ~lane_strobe(c_sz, c_a0) : 2'b11;
    write_n   = !(st == ST_DATA && c_wr);
    bus_req   = (st == ST_ARB);
    take_bus  = (st == ST_ARB) && bus_grant;
    cyc_done  = (st == ST_END);
    rel_ok    = (st == ST_IDLE) && !hreq;
    clr_rmw   = (st == ST_END) && c_rmw;
    clr_aonly = (st == ST_END) && c_aonly;
    set_berr  = (st == ST_DATA) && !berr_n;
    aonly_cyc = c_aonly && (st == ST_ADDR || st == ST_END);
    hack      = (st == ST_END) || (st == ST_RACK) || (st == ST_REJ);
    herr      = err_q && (st == ST_END || st == ST_REJ);
    hrdata    = rdata_q;
  end

endmodule

// File: rtl/vbus_master_ctl.sv
module vbus_master_ctl
  import vbm_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] CTRL_OFF = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hreq,
  input  logic              hwrite,
  input  logic [BUS_AW-1:0] haddr,
  input  logic [1:0]        hspace,
  input  logic [1:0]        hsize,
  input  logic [BUS_DW-1:0] hwdata,
  output logic              hack,
  output logic              herr,
  output logic [BUS_DW-1:0] hrdata,
  input  logic              rsel,
  input  logic              rwr,
  input  logic [OFF_W-1:0]  roff,
  input  logic [7:0]        rwdata,
  output logic [7:0]        rrdata,
  output logic              bus_req,
  input  logic              bus_grant,
  input  logic              bus_other_req,
  output logic              bbsy,
  output logic              as_n,
  output logic [1:0]        ds_n,
  output logic              write_n,
  output logic [1:0]        bus_space,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [BUS_DW-1:0] bus_dout,
  input  logic [BUS_DW-1:0] bus_din,
  input  logic              dtack_n,
  input  logic              berr_n,
  output logic              irq
);

  ctrl_t ctrl;
  logic  clr_rmw, clr_aonly, set_berr;
  logic  own, take_bus, cyc_done, rel_ok, aonly_cyc;
  logic  ctrl_berr, ctrl_rwd;

  assign ctrl_berr = ctrl.berr;
  assign ctrl_rwd  = ctrl.rwd;
  assign bbsy      = own;
  assign irq       = ctrl.berr && ctrl.ien;

  vbm_ctrl_reg #(.OFF_W(OFF_W), .CTRL_OFF(CTRL_OFF)) u_reg (
    .clk(clk), .rst_n(rst_n), .rsel(rsel), .rwr(rwr), .roff(roff),
    .rwdata(rwdata), .rrdata(rrdata), .clr_rmw(clr_rmw),
    .clr_aonly(clr_aonly), .set_berr(set_berr), .ctrl(ctrl)
  );

  vbm_owner u_own (
    .clk(clk), .rst_n(rst_n), .take_bus(take_bus), .cyc_done(cyc_done),
    .rwd(ctrl.rwd), .rel_ok(rel_ok), .other_req(bus_other_req), .own(own)
  );

  vbm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .hreq(hreq), .hwrite(hwrite), .haddr(haddr),
    .hspace(hspace), .hsize(hsize), .hwdata(hwdata), .hack(hack), .herr(herr),
    .hrdata(hrdata), .mode_rmw(ctrl.rmw), .mode_aonly(ctrl.aonly), .own(own),
    .take_bus(take_bus), .cyc_done(cyc_done), .rel_ok(rel_ok),
    .clr_rmw(clr_rmw), .clr_aonly(clr_aonly), .set_berr(set_berr),
    .aonly_cyc(aonly_cyc), .bus_req(bus_req), .bus_grant(bus_grant),
    .as_n(as_n), .ds_n(ds_n), .write_n(write_n), .bus_space(bus_space),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
    .dtack_n(dtack_n), .berr_n(berr_n)
  );

endmodule

// File: rtl/vbm_chk.sv
module vbm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       as_n,
  input logic [1:0] ds_n,
  input logic       bbsy,
  input logic       berr_n,
  input logic       hack,
  input logic       berr_flag,
  input logic       aonly_cyc,
  input logic       cyc_done,
  input logic       rwd
);

  // R3: a data strobe only inside an address strobe
  a_r3_ds_in_as: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_n != 2'b11) |-> !as_n);

  // R3: strobes only while the bus is owned
  a_r3_as_owned: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> bbsy);

  // R3: host acknowledge is a single-cycle pulse
  a_r3_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hack |=> !hack);

  // R6: no data strobe in an address-only cycle
  a_r6_no_ds: assert property (@(posedge clk) disable iff (!rst_n)
    aonly_cyc |-> (ds_n == 2'b11));

  // R8: a bus error in a data phase sets the flag
  a_r8_berr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!berr_n && ds_n != 2'b11) |=> berr_flag);

  // R10: keep ownership after a cycle
  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !rwd) |=> bbsy);

  // R11: release after every cycle
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && rwd) |=> !bbsy);

endmodule

bind vbus_master_ctl vbm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .bbsy(bbsy),
  .berr_n(berr_n), .hack(hack), .berr_flag(ctrl_berr), .aonly_cyc(aonly_cyc),
  .cyc_done(cyc_done), .rwd(ctrl_rwd)
);

// File: tb/test_vbus_master_ctl.sv
module test_vbus_master_ctl;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        hreq = 0, hwrite = 0;
  logic [31:0] haddr = 0, hwdata = 0;
  logic [1:0]  hspace = 0, hsize = 0;
  logic        hack, herr;
  logic [31:0] hrdata;
  logic        rsel = 0, rwr = 0;
  logic [7:0]  roff = 0, rwdata = 0, rrdata;
  logic        bus_req, bus_grant = 0, bus_other_req = 0, bbsy, as_n, write_n, irq;
  logic [1:0]  ds_n, bus_space;
  logic [31:0] bus_addr, bus_dout;
  logic [31:0] bus_din = 32'hA1B2C3D4;
  logic        dtack_n = 1, berr_n = 1;

  int nchk = 0, nfail = 0;
  int sdly = 1;
  logic s_berr = 0;
  int scnt = 0;

  // monitors
  logic m_as, m_req, m_wr, m_dtack, m_dsany, prev_as;
  logic [1:0]  m_ds;
  logic [31:0] m_dout, m_addr;
  int m_asrise;
  logic [31:0] r_data;
  logic r_err, r_dt;

  always #2 clk = ~clk;

  vbus_master_ctl i_vbus_master_ctl (
    .clk(clk), .rst_n(rst_n), .hreq(hreq), .hwrite(hwrite), .haddr(haddr),
    .hspace(hspace), .hsize(hsize), .hwdata(hwdata), .hack(hack), .herr(herr),
    .hrdata(hrdata), .rsel(rsel), .rwr(rwr), .roff(roff), .rwdata(rwdata),
    .rrdata(rrdata), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_other_req(bus_other_req), .bbsy(bbsy), .as_n(as_n), .ds_n(ds_n),
    .write_n(write_n), .bus_space(bus_space), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_din(bus_din), .dtack_n(dtack_n), .berr_n(berr_n),
    .irq(irq)
  );

  // arbiter and slave models
  always @(posedge clk) begin
    bus_grant <= bus_req;
    if (ds_n != 2'b11) begin
      scnt <= scnt + 1;
      if (scnt + 1 >= sdly) begin
        if (s_berr) berr_n <= 1'b0;
        else        dtack_n <= 1'b0;
      end
    end else begin
      scnt <= 0;
      dtack_n <= 1'b1;
      berr_n  <= 1'b1;
    end
  end

  always @(posedge clk) begin
    #1;
    if (!as_n) m_as = 1;
    if (bus_req) m_req = 1;
    if (!dtack_n) m_dtack = 1;
    if (ds_n != 2'b11) begin
      m_dsany = 1; m_ds = ds_n; m_addr = bus_addr;
      if (!write_n) begin m_wr = 1; m_dout = bus_dout; end
    end
    if (!prev_as && as_n) m_asrise++;
    prev_as = as_n;
  end

  task automatic clr_mon();
    m_as = 0; m_req = 0; m_wr = 0; m_dtack = 0; m_dsany = 0;
    m_ds = 2'b11; m_dout = 0; m_addr = 0; m_asrise = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk); rsel = 1; rwr = 1; roff = off; rwdata = d;
    @(negedge clk); rsel = 0; rwr = 0;
  endtask

  task automatic reg_rd(input logic [7:0] off, output logic [7:0] d);
    @(negedge clk); rsel = 1; rwr = 0; roff = off;
    #1 d = rrdata;
    rsel = 0;
  endtask

  task automatic access(input logic wr, input logic [1:0] sp, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] wd);
    int n;
    @(negedge clk);
    hreq = 1; hwrite = wr; hspace = sp; hsize = sz; haddr = a; hwdata = wd;
    n = 0;
    do begin @(negedge clk); n++; end while (!hack && n < 1000);
    if (!hack) begin nchk++; nfail++; $display("FAIL R3: no acknowledge, got 0 expected 1"); end
    r_data = hrdata; r_err = herr; r_dt = m_dtack;
    hreq = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_rd(8'h10, d);
    chk("R1 reg", {24'h0, d}, 32'h0);
    chk("R1 strobes", {27'h0, as_n, ds_n, bbsy, bus_req}, {27'h0, 1'b1, 2'b11, 1'b0, 1'b0});
    chk("R1 ack/irq", {30'h0, hack, irq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    reg_wr(8'h10, 8'hFF);
    reg_rd(8'h10, d);  chk("R2 layout", {24'h0, d}, 32'h3B); // bit2 write-one clears
    reg_rd(8'h00, d);  chk("R2 other offset", {24'h0, d}, 32'h0);
    reg_wr(8'h10, 8'h00);
    reg_rd(8'h10, d);  chk("R2 cleared", {24'h0, d}, 32'h0);
  endtask

  task automatic t_normal();
    clr_mon();
    access(0, 2'd2, 2'd2, 32'h8765_4320, 0);
    chk("R3 req raised", {31'h0, m_req}, 1);
    chk("R3 data", r_data, 32'hA1B2C3D4);
    chk("R3 no err", {31'h0, r_err}, 0);
    chk("R3 addr A32", m_addr, 32'h8765_4320);
    chk("R3 ack after dtack", {31'h0, r_dt}, 1);
    @(negedge clk);
    chk("R10 bbsy kept", {31'h0, bbsy}, 1);
  endtask

  task automatic t_lanes();
    clr_mon(); access(0, 2'd2, 2'd0, 32'h100, 0);
    chk("R4 even byte", r_data, 32'hC3); chk("R4 even ds", {30'h0, m_ds}, 2'b01);
    chk("R10 no req", {31'h0, m_req}, 0);
    clr_mon(); access(0, 2'd2, 2'd0, 32'h101, 0);
    chk("R4 odd byte", r_data, 32'hD4); chk("R4 odd ds", {30'h0, m_ds}, 2'b10);
    clr_mon(); access(0, 2'd2, 2'd1, 32'h102, 0);
    chk("R4 word", r_data, 32'hC3D4); chk("R4 word ds", {30'h0, m_ds}, 2'b00);
    clr_mon(); access(1, 2'd2, 2'd0, 32'h104, 32'hFFFF_FF5A);
    chk("R4 even wr lane", m_dout, 32'h5A00); chk("R4 even wr ds", {30'h0, m_ds}, 2'b01);
    clr_mon(); access(1, 2'd2, 2'd0, 32'h105, 32'h0000_005A);
    chk("R4 odd wr lane", m_dout, 32'h5A); chk("R4 odd wr ds", {30'h0, m_ds}, 2'b10);
    clr_mon(); access(1, 2'd3, 2'd2, 32'h108, 32'h1234_5678);
    chk("R4 long wr", m_dout, 32'h1234_5678);
  endtask

  task automatic t_ror_release();
    clr_mon(); access(0, 2'd0, 2'd1, 32'hABCD_1234, 0);
    chk("R3 A16 mask", m_addr, 32'h0000_1234);
    clr_mon(); access(0, 2'd1, 2'd1, 32'hABCD_1234, 0);
    chk("R3 A24 mask", m_addr, 32'h00CD_1234);
    @(negedge clk); bus_other_req = 1;
    @(negedge clk); bus_other_req = 0;
    chk("R10 released on request", {31'h0, bbsy}, 0);
  endtask

  task automatic t_rwd();
    reg_wr(8'h10, 8'h02);
    for (int i = 0; i < 2; i++) begin
      clr_mon(); access(0, 2'd2, 2'd2, 32'h200, 0);
      @(negedge clk);
      chk("R11 req each", {31'h0, m_req}, 1);
      chk("R11 released", {31'h0, bbsy}, 0);
    end
    reg_wr(8'h10, 8'h00);
  endtask

  task automatic t_rmw();
    logic [7:0] d;
    reg_wr(8'h10, 8'h01);
    clr_mon();
    access(0, 2'd2, 2'd1, 32'h300, 0);
    chk("R5 read data", r_data, 32'hC3D4);
    repeat (3) @(negedge clk);
    chk("R5 as held", {31'h0, as_n}, 0);
    access(1, 2'd2, 2'd1, 32'h300, 32'h0000_BEEF);
    @(negedge clk);
    chk("R5 single AS release", m_asrise, 1);
    chk("R5 write data", m_dout, 32'hBEEF);
    reg_rd(8'h10, d);
    chk("R5 self clear", {24'h0, d}, 32'h0);
  endtask

  task automatic t_aonly();
    logic [7:0] d;
    reg_wr(8'h10, 8'h20);
    clr_mon(); access(0, 2'd0, 2'd0, 32'h40, 0);
    chk("R6 as seen", {31'h0, m_as}, 1);
    chk("R6 no ds", {31'h0, m_dsany}, 0);
    chk("R6 no err", {31'h0, r_err}, 0);
    reg_rd(8'h10, d); chk("R6 self clear", {24'h0, d}, 32'h0);
    reg_wr(8'h10, 8'h20);
    clr_mon(); access(1, 2'd0, 2'd1, 32'h40, 0);
    chk("R7 write rejected", {31'h0, r_err}, 1);
    chk("R7 no as", {31'h0, m_as}, 0);
    clr_mon(); access(0, 2'd0, 2'd2, 32'h40, 0);
    chk("R7 long rejected", {31'h0, r_err}, 1);
    reg_rd(8'h10, d); chk("R7 bit kept", {24'h0, d}, 32'h20);
    reg_wr(8'h10, 8'h00);
  endtask

  task automatic t_berr();
    logic [7:0] d;
    s_berr = 1;
    clr_mon(); access(0, 2'd2, 2'd2, 32'h500, 0);
    s_berr = 0;
    chk("R8 err flag", {31'h0, r_err}, 1);
    chk("R8 ones", r_data, 32'hFFFF_FFFF);
    reg_rd(8'h10, d); chk("R8 bit set", {24'h0, d}, 32'h04);
    chk("R9 irq off", {31'h0, irq}, 0);
    reg_wr(8'h10, 8'h08);
    reg_rd(8'h10, d); chk("R8 zero write keeps", {24'h0, d}, 32'h0C);
    chk("R9 irq on", {31'h0, irq}, 1);
    reg_wr(8'h10, 8'h0C);
    reg_rd(8'h10, d); chk("R8 w1c", {24'h0, d}, 32'h08);
    chk("R9 irq cleared", {31'h0, irq}, 0);
    reg_wr(8'h10, 8'h00);
  endtask

  task automatic t_postwr();
    logic [7:0] d;
    reg_wr(8'h10, 8'h10);
    reg_rd(8'h10, d); chk("R12 readback", {24'h0, d}, 32'h10);
    sdly = 5;
    clr_mon(); access(1, 2'd2, 2'd2, 32'h600, 32'hCAFE_F00D);
    chk("R12 waits dtack", {31'h0, r_dt}, 1);
    chk("R12 no err", {31'h0, r_err}, 0);
    sdly = 1;
    reg_wr(8'h10, 8'h00);
  endtask

  initial begin
    prev_as = 1;
    clr_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_normal();
    t_lanes();
    t_ror_release();
    t_rwd();
    t_rmw();
    t_aonly();
    t_berr();
    t_postwr();
    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule